// File: doc/BRIEF.md
# Conditional Branch and Program Counter Unit

This block keeps the program counter of a 16-bit, byte-addressed load/store machine and decides where the next instruction comes from. It also holds the two condition bits, zero and negative, that every data-manipulation instruction updates. When the sequencer pulses the advance strobe, the unit looks at the current instruction word. A branch whose condition holds moves the PC by twice its signed 11-bit offset. Every other case moves the PC to the next word.

The flag-update strobe carries the ALU result of a data-manipulation instruction. The unit derives the zero and negative bits from that result and keeps them until the next update. Instruction fetch and the ALU itself sit outside this block. The fetch path reads the PC output, and the sequencer drives the two strobes.

Top module: `branch_pc_unit`

## Requirements
- R1: With `rst_n` low at a rising clock edge, the PC becomes 0x0000 and both the zero and negative flags become 0. After reset, BRNE (11010) and BRGE (11110) are therefore taken.
- R2: While `step_i` is low, the PC keeps its value at every clock edge, whatever the instruction and flag inputs are.
- R3: An instruction with bits 15:14 not equal to 2'b11 is not a branch. When `step_i` is high, it advances the PC by 2.
- R4: When `flag_we_i` is high at a clock edge, the zero flag becomes 1 exactly when `alu_res_i` is 0x0000, and the negative flag becomes `alu_res_i[15]`. When `flag_we_i` is low, both flags keep their values.
- R5: BRA (bits 15:11 = 11000) is always taken. A taken branch loads PC + 2 × offset, where the offset is bits 10:0 of the instruction.
- R6: The conditional opcodes in bits 15:11 are taken as follows: BREQ 11001 when Z; BRNE 11010 when !Z; BRLT 11011 when N; BRLE 11100 when N|Z; BRGT 11101 when !N&!Z; BRGE 11110 when !N. When the condition fails, the PC advances by 2.
- R7: Opcode 11111 is never taken and advances the PC by 2.
- R8: The offset is a signed two's-complement value (-1024..1023). The taken target wraps modulo 2^16.
- R9: When `step_i` and `flag_we_i` are high at the same edge, the branch decision uses the flags held before that edge, and the flags still take the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 16 | Current instruction word |
| flag_we_i | input | 1 | Load the condition flags from `alu_res_i` |
| alu_res_i | input | 16 | Result of the data-manipulation instruction |
| step_i | input | 1 | Advance the PC by one instruction decision |
| pc_o | output | 16 | Program counter (byte address) |

## Verification
The flags cannot be read directly, so a wrong flag state shows up only at the first conditional branch that depends on it. That branch's PC step then differs, one cycle after the edge where `step_i` is high. For this reason, the stimulus follows flag updates with conditional branches of every kind, including updates in the same cycle as a step. A wrong PC or target calculation appears on `pc_o` one cycle after the faulty step. Because the PC accumulates, that error then persists in every later comparison.

// File: rtl/bpu_pkg.sv
// Package: shared widths and branch condition encodings for the PC unit.
// Assumes a 5-bit branch opcode whose two top bits are 2'b11.
package bpu_pkg;
    localparam int XLEN  = 16;
    localparam int OFF_W = 11;
    localparam int OPC_W = 5;

    // Low three bits of a branch opcode select the condition.
    typedef enum logic [2:0] {
        COND_ALWAYS = 3'b000,
        COND_EQ     = 3'b001,
        COND_NE     = 3'b010,
        COND_LT     = 3'b011,
        COND_LE     = 3'b100,
        COND_GT     = 3'b101,
        COND_GE     = 3'b110,
        COND_NEVER  = 3'b111
    } cond_e;
endpackage

// File: rtl/bpu_flags.sv
// Module: condition flag register.
// Holds zero and negative bits; loads them from a result word when the
// write strobe is high. Assumes synchronous active-low reset.
module bpu_flags #(
    parameter int W = bpu_pkg::XLEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] res_i,
    output logic         z_o,
    output logic         n_o
);
    logic z_q;
    logic n_q;

    // Capture the flags from the result on a write, clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q <= 1'b0;
            n_q <= 1'b0;
        end else if (we_i) begin
            z_q <= (res_i == '0);
            n_q <= res_i[W-1];
        end
    end

    assign z_o = z_q;
    assign n_o = n_q;

    // R4
    flag_z_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (z_o == ($past(res_i) == '0)));
    // R4
    flag_n_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (n_o == $past(res_i[W-1])));
    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(z_o) && $stable(n_o)));
endmodule

// File: rtl/bpu_cond.sv
// Module: branch condition evaluator (combinational).
// Decides whether the instruction is a branch and whether it is taken,
// from the opcode field and the current flags. Assumes branch opcodes
// carry 2'b11 in their two top bits.
module bpu_cond #(
    parameter int OW = bpu_pkg::OPC_W
) (
    input  logic [OW-1:0] opc_i,
    input  logic          z_i,
    input  logic          n_i,
    output logic          taken_o
);
    import bpu_pkg::*;

    logic   is_branch;
    cond_e  cond;
    logic   cond_ok;

    assign is_branch = (opc_i[OW-1 -: 2] == 2'b11);
    assign cond      = cond_e'(opc_i[2:0]);

    // Map the condition selector onto the flag test.
    always_comb begin
        unique case (cond)
            COND_ALWAYS: cond_ok = 1'b1;
            COND_EQ:     cond_ok = z_i;
            COND_NE:     cond_ok = !z_i;
            COND_LT:     cond_ok = n_i;
            COND_LE:     cond_ok = n_i | z_i;
            COND_GT:     cond_ok = !n_i & !z_i;
            COND_GE:     cond_ok = !n_i;
            default:     cond_ok = 1'b0;
        endcase
    end

    assign taken_o = is_branch & cond_ok;

    // Guard: non-branches and the reserved code are never taken (R3, R7).
    always_comb begin
        // R7
        never_code_chk: assert (!(is_branch && opc_i[2:0] == 3'b111) || !taken_o);
        // R3
        non_branch_chk: assert (is_branch || !taken_o);
    end
endmodule

// File: rtl/bpu_target.sv
// Module: next-address adders.
// Produces the sequential address (PC + 2) and the branch target
// (PC + sign-extended offset * 2). Both wrap modulo 2^W.
module bpu_target #(
    parameter int W  = bpu_pkg::XLEN,
    parameter int OW = bpu_pkg::OFF_W
) (
    input  logic [W-1:0]  pc_i,
    input  logic [OW-1:0] off_i,
    output logic [W-1:0]  seq_o,
    output logic [W-1:0]  tgt_o
);
    localparam int EXT_W = W - OW - 1;

    logic [W-1:0] disp;

    // Sign-extend the offset and scale it by two (word-aligned targets).
    generate
        if (EXT_W > 0) begin : g_ext
            assign disp = {{EXT_W{off_i[OW-1]}}, off_i, 1'b0};
        end else begin : g_trunc
            assign disp = {off_i[W-2:0], 1'b0};
        end
    endgenerate

    assign seq_o = pc_i + W'(2);
    assign tgt_o = pc_i + disp;
endmodule

// File: rtl/branch_pc_unit.sv
// Module: top of the conditional branch / program counter unit.
// Holds the PC, chooses between the sequential and branch addresses on
// each advance strobe, and keeps the condition flags. The branch uses
// the flags held before the edge. Synchronous active-low reset.
module branch_pc_unit #(
    parameter int              W        = bpu_pkg::XLEN,
    parameter logic [15:0]     RESET_PC = 16'h0000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] instr_i,
    input  logic         flag_we_i,
    input  logic [W-1:0] alu_res_i,
    input  logic         step_i,
    output logic [W-1:0] pc_o
);
    import bpu_pkg::*;

    logic [W-1:0] pc_q;
    logic [W-1:0] seq_pc;
    logic [W-1:0] tgt_pc;
    logic         z_flag;
    logic         n_flag;
    logic         taken;

    bpu_flags #(.W(W)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (flag_we_i),
        .res_i (alu_res_i),
        .z_o   (z_flag),
        .n_o   (n_flag)
    );

    bpu_cond #(.OW(OPC_W)) u_cond (
        .opc_i   (instr_i[W-1 -: OPC_W]),
        .z_i     (z_flag),
        .n_i     (n_flag),
        .taken_o (taken)
    );

    bpu_target #(.W(W), .OW(OFF_W)) u_target (
        .pc_i  (pc_q),
        .off_i (instr_i[OFF_W-1:0]),
        .seq_o (seq_pc),
        .tgt_o (tgt_pc)
    );

    // Advance the PC on a step: branch target if taken, else next word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= W'(RESET_PC);
        end else if (step_i) begin
            pc_q <= taken ? tgt_pc : seq_pc;
        end
    end

    assign pc_o = pc_q;

    // R2
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(pc_o));
    // R3
    pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && instr_i[W-1 -: 2] != 2'b11) |=> (pc_o == $past(pc_o) + W'(2)));
    // R5
    pc_bra_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && instr_i[W-1 -: OPC_W] == 5'b11000)
        |=> (pc_o == $past(pc_o) + W'({{(W-OFF_W){$past(instr_i[OFF_W-1])}},
                                        $past(instr_i[OFF_W-1:0])} << 1)));
    // R8
    pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[0] == RESET_PC[0]);
endmodule

// File: tb/test_branch_pc_unit.sv
module test_branch_pc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic        fwe = 1'b0;
    logic [15:0] res = 16'h0000;
    logic        step = 1'b0;
    logic [15:0] pc;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_pc = 16'h0000;
    logic        m_z = 1'b0;
    logic        m_n = 1'b0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    branch_pc_unit i_branch_pc_unit (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .flag_we_i(fwe),
        .alu_res_i(res), .step_i(step), .pc_o(pc)
    );

    function automatic logic f_taken(input logic [4:0] opc, input logic z, input logic n);
        if (opc[4:3] != 2'b11) return 1'b0;
        case (opc[2:0])
            3'd0: return 1'b1;
            3'd1: return z;
            3'd2: return !z;
            3'd3: return n;
            3'd4: return n | z;
            3'd5: return !n && !z;
            3'd6: return !n;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] f_next(input logic [15:0] p, input logic [15:0] ins,
                                           input logic z, input logic n);
        int signed off;
        off = ins[10] ? int'(ins[10:0]) - 2048 : int'(ins[10:0]);
        if (f_taken(ins[15:11], z, n)) return p + 16'(off * 2);
        return p + 16'd2;
    endfunction

    function automatic logic [15:0] br(input logic [4:0] opc, input int off);
        return {opc, 11'(off)};
    endfunction

    task automatic check(input string tag, input logic [15:0] exp);
        n_chk++;
        if (pc !== exp) begin
            n_bad++;
            $display("FAIL %s: pc=%h expected %h", tag, pc, exp);
        end
    endtask

    // Apply one cycle of stimulus (called at a negedge), then compare.
    task automatic cyc(input logic [15:0] ins, input logic we, input logic [15:0] r,
                       input logic st, input string tag);
        instr = ins; fwe = we; res = r; step = st;
        @(posedge clk);
        if (st) m_pc = f_next(m_pc, ins, m_z, m_n);
        if (we) begin m_z = (r == 16'h0); m_n = r[15]; end
        @(negedge clk);
        check(tag, m_pc);
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'h5eed_0042);
        repeat (3) @(negedge clk);
        check("R1 reset pc", 16'h0000);
        rst_n = 1'b1;
        // R1: flags cleared -> BRNE and BRGE taken
        cyc(br(5'b11010, 5), 0, 0, 1, "R1 BRNE after reset");
        cyc(br(5'b11110, 3), 0, 0, 1, "R1 BRGE after reset");
        // R2: hold while step low, even with a taken-looking branch
        cyc(br(5'b11000, 100), 1, 16'h8000, 0, "R2 hold");
        cyc(br(5'b11000, 7), 0, 0, 0, "R2 hold again");
        // R3 non-branch
        cyc(16'h4123, 0, 0, 1, "R3 ADD step");
        cyc(16'hA0FF, 0, 0, 1, "R3 SETHI step");
        // R4 + R6: flags drive conditions
        cyc(16'h4000, 1, 16'h0000, 0, "R4 load zero");
        cyc(br(5'b11001, 10), 0, 0, 1, "R4 BREQ on Z");
        cyc(br(5'b11100, -3), 0, 0, 1, "R6 BRLE on Z");
        cyc(br(5'b11101, 9), 0, 0, 1, "R6 BRGT fails on Z");
        cyc(16'h4000, 1, 16'hFFF0, 0, "R4 load negative");
        cyc(br(5'b11011, -8), 0, 0, 1, "R6 BRLT on N");
        cyc(br(5'b11110, 40), 0, 0, 1, "R6 BRGE fails on N");
        cyc(16'h4000, 1, 16'h0001, 0, "R4 load positive");
        cyc(br(5'b11101, 12), 0, 0, 1, "R6 BRGT taken");
        cyc(br(5'b11011, 12), 0, 0, 1, "R6 BRLT fails");
        cyc(16'h0000, 0, 16'h0000, 0, "R4 flags held");
        cyc(br(5'b11101, 2), 0, 0, 1, "R4 hold seen via BRGT");
        // R7 reserved code
        cyc(br(5'b11111, 50), 0, 0, 1, "R7 code 11111");
        // R5 / R8: extremes and wrap
        cyc(br(5'b11000, -1024), 0, 0, 1, "R8 BRA min offset wraps");
        cyc(br(5'b11000, 1023), 0, 0, 1, "R5 BRA max offset");
        cyc(br(5'b11000, -1), 0, 0, 1, "R8 BRA -1");
        // R9: step and flag write together use old flags
        cyc(br(5'b11001, 20), 1, 16'h0000, 1, "R9 BREQ with same-edge zero");
        cyc(br(5'b11001, 20), 0, 0, 1, "R9 BREQ after zero");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ins;
            logic [15:0] r;
            ins = 16'($urandom);
            if ($urandom_range(0, 1) == 0) ins[15:14] = 2'b11;
            r = 16'($urandom);
            if ($urandom_range(0, 4) == 0) r = 16'h0000;
            cyc(ins, 1'($urandom_range(0, 1)), r, ($urandom_range(0, 3) != 0),
                (ins[15:14] == 2'b11) ? "R6 random branch" : "R3 random other");
        end
        // R1: reset in mid-run
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 re-reset pc", 16'h0000);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule